// File: doc/BRIEF.md
# Ping-pong receive endpoint buffer

This block holds the incoming payloads of one OUT endpoint of a USB device in two memory banks that take turns. A packet receiver supplies bytes with a valid strobe, then ends each packet with either a good-end strobe or an error strobe. The block replies to each good end with an ACK or NAK pulse. The first payload goes to bank 0, the next to bank 1, and so on. A bank that holds a payload stays locked until the processor releases it, so the receiver can fill one bank while the processor empties the other. This overlap is what keeps isochronous traffic flowing at a constant rate.

On the processor side, each bank has its own full flag, and an interrupt line is raised while either flag is set. The serviced bank is always the older of the full banks. For that bank the block shows the byte count and a first-word-fall-through read port, which steps forward one byte per read strobe. Each bank has a release strobe that hands the bank back to the receiver.

The `ISO` parameter sets how the block treats a packet that arrives when its target bank is still locked. With `ISO=0` the block answers NAK. With `ISO=1` it drops the packet and sends no handshake.

Top module: `pprx_rx_buf`

## Requirements
- R1: After reset both full flags are 0, `irq` is 0, `hs_ack` and `hs_nak` are 0, `byte_cnt` is 0, `rd_bank` is 0, and the first packet is aimed at bank 0.
- R2: A good packet stored in a free bank sets that bank's flag (bit 0 of `bank_full` is bank 0, bit 1 is bank 1). `hs_ack` pulses for exactly one cycle, in the cycle after the `rx_end_ok` cycle. The count stored for the bank equals the number of bytes received.
- R3: Stored payloads go to bank 0, then bank 1, then keep alternating. A payload that follows a release lands in the bank the alternation points to.
- R4: `irq` is high exactly while at least one bank flag is set.
- R5: `rd_data` shows the byte at the read pointer of the serviced bank, and `byte_cnt` shows that bank's count. Each `rd_en` moves the pointer forward one byte. `rd_en` has no effect once the pointer has reached the count, or when no bank is full.
- R6: `rd_bank` names the older full bank. When that bank is released, the serviced bank moves to the other bank if it is full, and reading restarts at byte 0.
- R7: A `rel_bank[b]` pulse clears the flag of bank b. A pulse for a bank that is already empty changes nothing. If a packet arrives while its target bank is locked, it is not stored, the flags and stored data stay as they were, and with `ISO=0` it is answered by a single `hs_nak` pulse one cycle after `rx_end_ok`.
- R8: With `ISO=1`, a packet that arrives while its target bank is locked is dropped without any `hs_ack` or `hs_nak`.
- R9: A packet ended by `rx_end_bad` is discarded: no flag is set and no handshake is sent. The next packet goes to the same bank the discarded one was aimed at.
- R10: A packet longer than `DEPTH` bytes (64 by default) is discarded with no flag and no handshake. A packet of exactly `DEPTH` bytes is stored with a count of `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte strobe from the packet receiver |
| rx_byte | input | DATA_W | Received byte |
| rx_end_ok | input | 1 | Packet ended cleanly (given in a cycle with no byte) |
| rx_end_bad | input | 1 | Packet ended in error |
| hs_ack | output | 1 | One-cycle ACK reply |
| hs_nak | output | 1 | One-cycle NAK reply |
| bank_full | output | 2 | Per-bank data-received flags |
| rd_bank | output | 1 | Index of the serviced bank |
| byte_cnt | output | CNT_W | Byte count of the serviced bank, 0 when none is full |
| rd_en | input | 1 | Advance the read pointer by one byte |
| rd_data | output | DATA_W | Byte at the read pointer |
| rel_bank | input | 2 | Per-bank release strobes |
| irq | output | 1 | Interrupt, high while any flag is set |

## Verification
The bench fills both banks and then sends a third packet. A design that failed to lock a full bank would overwrite the older payload, or would ACK a packet it never kept. The bench releases the serviced bank in the middle of the sequence and also releases a bank that is already empty. These steps catch a read pointer that does not restart at 0, a serviced bank that follows the wrong age order, and an empty release that upsets a flag. Error-terminated packets, 65-byte packets and exactly 64-byte packets are aimed at the limits. A wrong design here would ACK garbage, would set a flag, or would move the alternation past a discarded packet. Reads past the end of a bank must leave the data and the count unchanged.

// File: rtl/pprx_pkg.sv
package pprx_pkg;

  // Bank the processor is served from: the only full one, or when both are
  // full the next write target, which is the older of the two.
  function automatic logic serviced_bank(input logic [1:0] full, input logic wr_bank);
    logic sel;
    case (full)
      2'b01:   sel = 1'b0;
      2'b10:   sel = 1'b1;
      default: sel = wr_bank;
    endcase
    return sel;
  endfunction

  function automatic logic [1:0] bank_mask(input logic bank);
    return bank ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/pprx_bank.sv
module pprx_bank #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cnt_load,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        count <= '0;
    else if (cnt_load) count <= cnt_val;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pprx_wr_ctrl.sv
module pprx_wr_ctrl #(
  parameter int DEPTH = 64,
  parameter bit ISO   = 1'b0,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_end_ok,
  input  logic             rx_end_bad,
  input  logic [1:0]       bank_full,
  output logic             wr_bank,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [1:0]       done_set,
  output logic [CNT_W-1:0] done_cnt,
  output logic             hs_ack,
  output logic             hs_nak,
  output logic             evt_drop
);
  logic             pkt_open, pkt_drop, pkt_ovf;
  logic [CNT_W-1:0] wr_ptr;
  logic             active, ending, drop_eff, byte_ok, ovf_eff, good, nak_c;
  logic [CNT_W-1:0] ptr_eff;

  always_comb begin
    active   = rx_valid | rx_end_ok | rx_end_bad;
    ending   = rx_end_ok | rx_end_bad;
    drop_eff = pkt_open ? pkt_drop : bank_full[wr_bank];
    byte_ok  = rx_valid & ~drop_eff & ~pkt_ovf & (wr_ptr < CNT_W'(DEPTH));
    ovf_eff  = pkt_ovf | (rx_valid & ~drop_eff & (wr_ptr == CNT_W'(DEPTH)));
    ptr_eff  = wr_ptr + CNT_W'(byte_ok);
    good     = rx_end_ok & ~rx_end_bad & ~drop_eff & ~ovf_eff;
    nak_c    = rx_end_ok & ~rx_end_bad & drop_eff & (ISO == 1'b0);
    evt_drop = ending & drop_eff;
  end

  assign wr_en    = byte_ok;
  assign wr_addr  = wr_ptr[PTR_W-1:0];
  assign done_set = good ? pprx_pkg::bank_mask(wr_bank) : 2'b00;
  assign done_cnt = ptr_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_open <= 1'b0;
      pkt_drop <= 1'b0;
      pkt_ovf  <= 1'b0;
      wr_ptr   <= '0;
      wr_bank  <= 1'b0;
      hs_ack   <= 1'b0;
      hs_nak   <= 1'b0;
    end else begin
      hs_ack <= good;
      hs_nak <= nak_c;
      if (ending) begin
        pkt_open <= 1'b0;
        pkt_drop <= 1'b0;
        pkt_ovf  <= 1'b0;
        wr_ptr   <= '0;
        if (good) wr_bank <= ~wr_bank;
      end else if (active) begin
        pkt_open <= 1'b1;
        pkt_drop <= drop_eff;
        pkt_ovf  <= ovf_eff;
        wr_ptr   <= ptr_eff;
      end
    end
  end
endmodule

// File: rtl/pprx_flags.sv
module pprx_flags #(
  parameter int NBANK = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBANK-1:0] set,
  input  logic [NBANK-1:0] clr_req,
  output logic [NBANK-1:0] full,
  output logic [NBANK-1:0] clr_eff
);
  for (genvar b = 0; b < NBANK; b++) begin : g_flag
    assign clr_eff[b] = clr_req[b] & full[b];
    always_ff @(posedge clk) begin
      if (!rst_n)          full[b] <= 1'b0;
      else if (set[b])     full[b] <= 1'b1;
      else if (clr_eff[b]) full[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/pprx_rd_ctrl.sv
module pprx_rd_ctrl #(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       full,
  input  logic [1:0]       clr_eff,
  input  logic             wr_bank,
  input  logic             rd_en,
  input  logic [CNT_W-1:0] cnt0,
  input  logic [CNT_W-1:0] cnt1,
  output logic             rd_sel,
  output logic [PTR_W-1:0] rd_addr,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             rd_adv
);
  logic [CNT_W-1:0] rd_ptr, cnt_sel;

  always_comb begin
    rd_sel   = pprx_pkg::serviced_bank(full, wr_bank);
    cnt_sel  = rd_sel ? cnt1 : cnt0;
    byte_cnt = full[rd_sel] ? cnt_sel : '0;
    rd_adv   = rd_en & full[rd_sel] & (rd_ptr < cnt_sel);
  end

  assign rd_addr = rd_ptr[PTR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)               rd_ptr <= '0;
    else if (clr_eff[rd_sel]) rd_ptr <= '0;
    else if (rd_adv)          rd_ptr <= rd_ptr + 1'b1;
  end
endmodule

// File: rtl/pprx_rx_buf.sv
module pprx_rx_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter bit ISO    = 1'b0,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_end_ok,
  input  logic              rx_end_bad,
  output logic              hs_ack,
  output logic              hs_nak,
  output logic [1:0]        bank_full,
  output logic              rd_bank,
  output logic [CNT_W-1:0]  byte_cnt,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        rel_bank,
  output logic              irq
);
  // named internal events, used by the checker
  logic             wr_bank, wr_en, rd_sel, rd_adv, evt_drop;
  logic [PTR_W-1:0] wr_addr, rd_addr;
  logic [1:0]       bank_set, clr_eff;
  logic [CNT_W-1:0] done_cnt;
  logic [DATA_W-1:0] bk_rd  [2];
  logic [CNT_W-1:0]  bk_cnt [2];

  pprx_wr_ctrl #(.DEPTH(DEPTH), .ISO(ISO)) u_wr (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_end_ok(rx_end_ok),
    .rx_end_bad(rx_end_bad), .bank_full(bank_full), .wr_bank(wr_bank),
    .wr_en(wr_en), .wr_addr(wr_addr), .done_set(bank_set), .done_cnt(done_cnt),
    .hs_ack(hs_ack), .hs_nak(hs_nak), .evt_drop(evt_drop)
  );

  pprx_flags #(.NBANK(2)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(bank_set), .clr_req(rel_bank),
    .full(bank_full), .clr_eff(clr_eff)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    pprx_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en & (wr_bank == 1'(b))), .wr_addr(wr_addr), .wr_data(rx_byte),
      .cnt_load(bank_set[b]), .cnt_val(done_cnt),
      .rd_addr(rd_addr), .rd_data(bk_rd[b]), .count(bk_cnt[b])
    );
  end

  pprx_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_n), .full(bank_full), .clr_eff(clr_eff),
    .wr_bank(wr_bank), .rd_en(rd_en), .cnt0(bk_cnt[0]), .cnt1(bk_cnt[1]),
    .rd_sel(rd_sel), .rd_addr(rd_addr), .byte_cnt(byte_cnt), .rd_adv(rd_adv)
  );

  assign rd_bank = rd_sel;
  assign rd_data = bk_rd[rd_sel];
  assign irq     = |bank_full;
endmodule

// File: rtl/pprx_chk.sv
module pprx_chk #(
  parameter int DEPTH = 64,
  parameter bit ISO   = 1'b0,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_end_ok,
  input logic             rx_end_bad,
  input logic             hs_ack,
  input logic             hs_nak,
  input logic [1:0]       bank_full,
  input logic             irq,
  input logic [CNT_W-1:0] byte_cnt,
  input logic [1:0]       bank_set,
  input logic [1:0]       clr_eff,
  input logic             rd_sel,
  input logic [PTR_W-1:0] rd_addr,
  input logic             rd_adv,
  input logic             evt_drop
);
  // R2
  ack_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_ack |-> $past(rx_end_ok));
  // R2
  ack_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_ack |-> (bank_full != 2'b00));
  // R4
  irq_on_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_set != 2'b00) |=> irq);
  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= CNT_W'(DEPTH));
  // R5
  adv_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_adv |-> (byte_cnt != '0));
  // R6
  ptr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_eff[rd_sel] |=> (rd_addr == '0));
  // R7
  nak_from_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_nak |-> $past(evt_drop));
  // R7
  ack_nak_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_ack && hs_nak));
  // R8
  iso_no_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ISO == 1'b1) |-> !hs_nak);
  // R9
  bad_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end_bad |=> (!hs_ack && !hs_nak));
endmodule

bind pprx_rx_buf pprx_chk #(.DEPTH(DEPTH), .ISO(ISO)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_end_ok(rx_end_ok), .rx_end_bad(rx_end_bad),
  .hs_ack(hs_ack), .hs_nak(hs_nak), .bank_full(bank_full), .irq(irq),
  .byte_cnt(byte_cnt), .bank_set(bank_set), .clr_eff(clr_eff), .rd_sel(rd_sel),
  .rd_addr(rd_addr), .rd_adv(rd_adv), .evt_drop(evt_drop)
);

// File: tb/pprx_rx_buf_tb_top.sv
module pprx_rx_buf_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, rx_end_ok = 1'b0, rx_end_bad = 1'b0, rd_en = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [1:0] rel_bank = '0;

  logic       hs_ack, hs_nak, rd_bank, irq;
  logic [1:0] bank_full;
  logic [6:0] byte_cnt;
  logic [7:0] rd_data;
  logic       hs_ack_i, hs_nak_i, rd_bank_i, irq_i;
  logic [1:0] bank_full_i;
  logic [6:0] byte_cnt_i;
  logic [7:0] rd_data_i;

  int tests = 0, fails = 0;
  logic [7:0] exp_q [$];

  always #2 clk = ~clk;

  pprx_rx_buf #(.ISO(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_end_ok(rx_end_ok), .rx_end_bad(rx_end_bad), .hs_ack(hs_ack), .hs_nak(hs_nak),
    .bank_full(bank_full), .rd_bank(rd_bank), .byte_cnt(byte_cnt), .rd_en(rd_en),
    .rd_data(rd_data), .rel_bank(rel_bank), .irq(irq));

  pprx_rx_buf #(.ISO(1'b1)) dut_iso (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_end_ok(rx_end_ok), .rx_end_bad(rx_end_bad), .hs_ack(hs_ack_i), .hs_nak(hs_nak_i),
    .bank_full(bank_full_i), .rd_bank(rd_bank_i), .byte_cnt(byte_cnt_i), .rd_en(rd_en),
    .rd_data(rd_data_i), .rel_bank(rel_bank), .irq(irq_i));

  task automatic tick; @(negedge clk); endtask

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: sends a packet; expect 0 none, 1 ACK, 2 NAK; pushes stored bytes
  task automatic send_pkt(input int len, input int seed, input bit bad,
                          input int expect_hs, input string req);
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1; rx_byte = 8'(seed + i); tick;
    end
    rx_valid = 1'b0; rx_end_ok = ~bad; rx_end_bad = bad; tick;
    rx_end_ok = 1'b0; rx_end_bad = 1'b0;
    check({req, " ack"}, int'(hs_ack), int'(expect_hs == 1));
    check({req, " nak"}, int'(hs_nak), int'(expect_hs == 2));
    check({req, " iso ack"}, int'(hs_ack_i), int'(expect_hs == 1));
    check("R8 iso nak", int'(hs_nak_i), 0);
    if (expect_hs == 1)
      for (int i = 0; i < len; i++) exp_q.push_back(8'(seed + i));
    tick;
    check({req, " ack pulse"}, int'(hs_ack), 0);
  endtask

  // monitor side of the scoreboard: pops expected bytes as the port yields them
  task automatic drain(input int n, input string req);
    logic [7:0] held;
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = exp_q.pop_front();
      check({req, " data"}, int'(rd_data), int'(e));
      check({req, " iso data"}, int'(rd_data_i), int'(e));
      rd_en = 1'b1; tick; rd_en = 1'b0;
    end
    held = rd_data;
    rd_en = 1'b1; tick; rd_en = 1'b0;
    check("R5 read past end data", int'(rd_data), int'(held));
    check("R5 read past end count", int'(byte_cnt), n);
  endtask

  task automatic release_bank(input int b);
    rel_bank = 2'(1 << b); tick; rel_bank = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) tick;
    rst_n = 1'b1; tick;
    check("R1 flags", int'(bank_full), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 ack", int'(hs_ack), 0);
    check("R1 count", int'(byte_cnt), 0);
    check("R1 rd_bank", int'(rd_bank), 0);

    send_pkt(5, 8'h10, 1'b0, 1, "R2");
    check("R3 first in bank0", int'(bank_full), 1);
    check("R4 irq", int'(irq), 1);
    check("R2 count", int'(byte_cnt), 5);
    check("R6 rd_bank", int'(rd_bank), 0);

    send_pkt(3, 8'h40, 1'b0, 1, "R2");
    check("R3 second in bank1", int'(bank_full), 3);
    check("R6 older kept", int'(rd_bank), 0);
    check("R6 older count", int'(byte_cnt), 5);

    send_pkt(4, 8'h80, 1'b0, 2, "R7");
    check("R7 flags unchanged", int'(bank_full), 3);
    check("R8 iso flags unchanged", int'(bank_full_i), 3);
    check("R7 count unchanged", int'(byte_cnt), 5);

    drain(5, "R5");
    release_bank(0);
    check("R7 release clears", int'(bank_full), 2);
    check("R6 move to bank1", int'(rd_bank), 1);
    check("R6 new count", int'(byte_cnt), 3);
    drain(3, "R6");

    release_bank(0);
    check("R7 empty release flags", int'(bank_full), 2);
    check("R7 empty release count", int'(byte_cnt), 3);

    send_pkt(2, 8'hA0, 1'b0, 1, "R3");
    check("R3 third in bank0", int'(bank_full), 3);
    check("R6 still bank1", int'(rd_bank), 1);
    release_bank(1);
    check("R6 move to bank0", int'(rd_bank), 0);
    check("R6 count bank0", int'(byte_cnt), 2);
    drain(2, "R6");
    release_bank(0);
    check("R4 irq low", int'(irq), 0);

    send_pkt(3, 8'h20, 1'b1, 0, "R9");
    check("R9 no flag", int'(bank_full), 0);
    send_pkt(2, 8'h30, 1'b0, 1, "R9");
    check("R9 same target bank1", int'(bank_full), 2);
    drain(2, "R9");
    release_bank(1);

    send_pkt(65, 8'h00, 1'b0, 0, "R10");
    check("R10 long dropped", int'(bank_full), 0);
    send_pkt(64, 8'h55, 1'b0, 1, "R10");
    check("R10 full size flag", int'(bank_full), 1);
    check("R10 full size count", int'(byte_cnt), 64);
    drain(64, "R10");
    release_bank(0);
    check("R4 final irq", int'(irq), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule